// File: doc/BRIEF.md
# Watermarked Circular Sample Buffer

This block keeps a ring of 16-bit samples inside a window of a shared local memory. The window is given by a base address and a length in words. Samples arrive on a valid/ready write stream and are stored at the write position. The position then steps forward and wraps back to the start of the window. A datapath consumer reads the oldest sample still in use on `oldest_data`, and pulses `consume` to release it. Releasing a sample frees one location in the window.

The block computes the free space left in the window and raises a full flag when that space drops below a programmable power-of-two watermark. The flag follows the free space with a fixed lag of three clock cycles. While the buffer is not full, the block can hold a write interrupt request and a DMA write request, which lets a producer move several samples per request. A write that finds no free location is dropped and sets a sticky overflow flag. Only a unit clear or the chip reset removes that flag.

The write stream has a simple back-pressure rule. `s_ready` equals `run`, so samples are accepted whenever the unit is running. Watching the full flag is the producer's job. A sample offered while `run` is low is not accepted and has no effect. The configuration inputs are expected to stay constant while `run` is high.

Top module: `sample_ring`

## Requirements
- R1: The n-th stored sample since the last clear is placed at address (base + (n mod size)) mod 2^AW. `oldest_data` shows the oldest unreleased sample, so samples come out in write order across any number of wraps of the window.
- R2: `s_ready` equals `run`. A beat transfers when `s_valid` and `s_ready` are both high. A beat offered while `run` is low is not stored and does not move the write position.
- R3: A transferred beat is stored only if free space (size minus unreleased samples) is nonzero. This is judged on the occupancy before the clock edge, even if `consume` is high on the same edge. Otherwise the beat is dropped and `ovfl` goes high. `ovfl` then stays high until `unit_clr` or reset.
- R4: The full condition is free space < 2^wm, where the 2-bit `cfg_wm` value n selects a threshold of 1, 2, 4 or 8 for n = 0, 1, 2, 3.
- R5: `full` shows the full condition as it was three clock edges earlier. It rises on the third edge after the edge that stored the write crossing the threshold, and it falls on the third edge after the releasing edge.
- R6: A `consume` pulse while `run` is high and at least one sample is unreleased releases the oldest sample. A `consume` pulse on an empty buffer, or while `run` is low, has no effect.
- R7: `wr_irq` is high exactly when `wr_irq_en` is high and `full` is low. `ovf_irq` is high exactly when `ovf_irq_en` is high and `ovfl` is high.
- R8: `dma_req` is high when the captured DMA enable is high and `full` is low. The captured enable copies `dma_wr_en` only on edges where `run` is low, so changes to `dma_wr_en` while running are ignored.
- R9: After reset, or on the edge after `unit_clr`, the buffer is empty, `ovfl` is low and the lag stages hold zero, so `full` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| unit_clr | input | 1 | Unit clear: empties the ring, clears overflow and the full lag |
| run | input | 1 | Unit running; enables transfers and releases |
| cfg_base | input | AW | Window base address |
| cfg_size | input | AW | Window length in 16-bit words |
| cfg_wm | input | 2 | Full watermark exponent |
| wr_irq_en | input | 1 | Write interrupt enable |
| ovf_irq_en | input | 1 | Overflow interrupt enable |
| dma_wr_en | input | 1 | DMA write enable (captured while stopped) |
| s_valid | input | 1 | Write stream valid |
| s_ready | output | 1 | Write stream ready |
| s_data | input | DW | Write stream sample |
| consume | input | 1 | Release the oldest sample |
| oldest_data | output | DW | Oldest unreleased sample |
| full | output | 1 | Lagged full flag |
| ovfl | output | 1 | Sticky overflow flag |
| wr_irq | output | 1 | Write interrupt request |
| ovf_irq | output | 1 | Overflow interrupt request |
| dma_req | output | 1 | DMA write request |

## Verification
The fill-and-drain sweep runs every window length from 1 to 9 against every watermark, at bases 0, 100 and 250. Base 250 makes the addresses also wrap at the top of the memory. Because the flag is checked two and three edges after each single write and each single release, an off-by-one in the threshold compare can be told apart from a wrong lag. The same sweep also forces a write into a full window, which shows the difference between a dropped beat that sets overflow and one that silently overwrites the oldest sample. A streaming pattern of alternating write and release, run for more than twice the window length, shows whether the ring wraps at base plus size or runs past the window. Separate short patterns send beats and releases while stopped, and a release on an empty ring, and then check through `oldest_data` that nothing moved.

// File: rtl/sample_ring_pkg.sv
package sample_ring_pkg;

  // Clock edges between a change of free space and the visible full flag
  localparam int unsigned FULL_LAG = 3;

  // Watermark exponent to threshold: 0->1, 1->2, 2->4, 3->8
  function automatic int unsigned wm_threshold(input logic [1:0] wm);
    return 32'd1 << wm;
  endfunction

endpackage

// File: rtl/sample_ring_ptr.sv
module sample_ring_ptr #(
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          adv,
  input  logic [AW-1:0] base,
  input  logic [AW-1:0] size,
  output logic [AW-1:0] addr
);

  logic [AW-1:0] off_q;
  logic          at_end;

  assign at_end = (off_q == size - 1'b1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      off_q <= '0;
    else if (clr)    off_q <= '0;
    else if (adv)    off_q <= at_end ? '0 : off_q + 1'b1;
  end

  // Window offset folded onto the memory address space
  assign addr = base + off_q;

  // R1: stepping past the last word of the window returns to its start
  a_r1_ptr_wraps: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !clr && size != '0 && off_q == size - 1'b1) |=> (off_q == '0));

endmodule

// File: rtl/sample_ring_fill.sv
module sample_ring_fill #(
  parameter int AW = 8,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic          wr,
  input  logic          cons,
  input  logic [AW-1:0] size,
  output logic [CW-1:0] free,
  output logic          store,
  output logic          take,
  output logic          ovfl
);

  logic [CW-1:0] used_q;
  logic [CW-1:0] size_x;

  assign size_x = {1'b0, size};
  assign free   = (used_q > size_x) ? '0 : size_x - used_q;
  assign store  = wr && (free != '0);
  assign take   = cons && (used_q != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (clr) begin
      used_q <= '0;
    end else begin
      case ({store, take})
        2'b10:   used_q <= used_q + 1'b1;
        2'b01:   used_q <= used_q - 1'b1;
        default: used_q <= used_q;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                     ovfl <= 1'b0;
    else if (clr)                   ovfl <= 1'b0;
    else if (wr && free == '0)      ovfl <= 1'b1;
  end

  // R3: a beat landing on a window with no room raises overflow
  a_r3_ovfl_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && free == '0 && !clr) |=> ovfl);

  // R3: overflow stays until a unit clear
  a_r3_ovfl_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovfl && !clr) |=> ovfl);

  // R6: with nothing stored and nothing written, occupancy cannot move
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
    (used_q == '0 && !wr) |=> (used_q == '0));

endmodule

// File: rtl/sample_ring_full_lag.sv
module sample_ring_full_lag
  import sample_ring_pkg::*;
#(
  parameter int CW  = 9,
  parameter int LAG = FULL_LAG
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clr,
  input  logic [CW-1:0] free,
  input  logic [1:0]    wm,
  output logic          full
);

  logic [CW-1:0] thr;
  logic          low;

  assign thr = CW'(wm_threshold(wm));
  assign low = (free < thr);

  generate
    if (LAG <= 1) begin : g_single
      logic st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= 1'b0;
        else if (clr) st_q <= 1'b0;
        else          st_q <= low;
      end
      assign full = st_q;
    end else begin : g_chain
      logic [LAG-1:0] st_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)   st_q <= '0;
        else if (clr) st_q <= '0;
        else          st_q <= {st_q[LAG-2:0], low};
      end
      assign full = st_q[LAG-1];
    end
  endgenerate

  generate
    if (LAG == 3) begin : g_chk
      // R5: the flag only rises when the threshold was crossed three edges back
      a_r5_rise_lag: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(full) |-> $past(low, 3));
    end
  endgenerate

endmodule

// File: rtl/sample_ring_mem.sv
module sample_ring_mem #(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] words [DEPTH];

  always_ff @(posedge clk) begin
    if (we) words[waddr] <= wdata;
  end

  assign rdata = words[raddr];

endmodule

// File: rtl/sample_ring.sv
module sample_ring
  import sample_ring_pkg::*;
#(
  parameter int AW = 8,
  parameter int DW = 16,
  localparam int CW = AW + 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          unit_clr,
  input  logic          run,
  input  logic [AW-1:0] cfg_base,
  input  logic [AW-1:0] cfg_size,
  input  logic [1:0]    cfg_wm,
  input  logic          wr_irq_en,
  input  logic          ovf_irq_en,
  input  logic          dma_wr_en,
  input  logic          s_valid,
  output logic          s_ready,
  input  logic [DW-1:0] s_data,
  input  logic          consume,
  output logic [DW-1:0] oldest_data,
  output logic          full,
  output logic          ovfl,
  output logic          wr_irq,
  output logic          ovf_irq,
  output logic          dma_req
);

  logic          beat;
  logic          cons_req;
  logic          store;
  logic          take;
  logic [CW-1:0] free;
  logic [AW-1:0] wr_addr;
  logic [AW-1:0] rd_addr;
  logic          dma_en_q;

  assign s_ready  = run;
  assign beat     = s_valid && s_ready;
  assign cons_req = consume && run;

  sample_ring_fill #(.AW(AW)) u_fill (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (unit_clr),
    .wr    (beat),
    .cons  (cons_req),
    .size  (cfg_size),
    .free  (free),
    .store (store),
    .take  (take),
    .ovfl  (ovfl)
  );

  sample_ring_ptr #(.AW(AW)) u_wr_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (unit_clr),
    .adv   (store && !unit_clr),
    .base  (cfg_base),
    .size  (cfg_size),
    .addr  (wr_addr)
  );

  sample_ring_ptr #(.AW(AW)) u_rd_ptr (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (unit_clr),
    .adv   (take && !unit_clr),
    .base  (cfg_base),
    .size  (cfg_size),
    .addr  (rd_addr)
  );

  sample_ring_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (store && !unit_clr),
    .waddr (wr_addr),
    .wdata (s_data),
    .raddr (rd_addr),
    .rdata (oldest_data)
  );

  sample_ring_full_lag #(.CW(CW), .LAG(FULL_LAG)) u_lag (
    .clk   (clk),
    .rst_n (rst_n),
    .clr   (unit_clr),
    .free  (free),
    .wm    (cfg_wm),
    .full  (full)
  );

  // DMA enable is sampled only while the unit is stopped
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   dma_en_q <= 1'b0;
    else if (!run) dma_en_q <= dma_wr_en;
  end

  assign wr_irq  = wr_irq_en && !full;
  assign ovf_irq = ovf_irq_en && ovfl;
  assign dma_req = dma_en_q && !full;

  // R8: the captured DMA enable holds across any running edge
  a_r8_dma_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    run |=> $stable(dma_en_q));

endmodule

// File: tb/sample_ring_tb.sv
module sample_ring_tb;

  localparam int AW = 8;
  localparam int DW = 16;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          unit_clr = 1'b0;
  logic          run = 1'b0;
  logic [AW-1:0] cfg_base = '0;
  logic [AW-1:0] cfg_size = '0;
  logic [1:0]    cfg_wm = '0;
  logic          wr_irq_en = 1'b0;
  logic          ovf_irq_en = 1'b0;
  logic          dma_wr_en = 1'b0;
  logic          s_valid = 1'b0;
  logic          s_ready;
  logic [DW-1:0] s_data = '0;
  logic          consume = 1'b0;
  logic [DW-1:0] oldest_data;
  logic          full, ovfl, wr_irq, ovf_irq, dma_req;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  sample_ring #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .unit_clr(unit_clr), .run(run),
    .cfg_base(cfg_base), .cfg_size(cfg_size), .cfg_wm(cfg_wm),
    .wr_irq_en(wr_irq_en), .ovf_irq_en(ovf_irq_en), .dma_wr_en(dma_wr_en),
    .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .consume(consume), .oldest_data(oldest_data),
    .full(full), .ovfl(ovfl), .wr_irq(wr_irq), .ovf_irq(ovf_irq),
    .dma_req(dma_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d (t=%0t)", req, act, exp, $time);
    end
  endtask

  task automatic chk_eq(input string req, input int act, input int exp);
    check(act == exp, req, act, exp);
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic push(input logic [DW-1:0] d);
    s_valid = 1'b1;
    s_data  = d;
    tick();
    s_valid = 1'b0;
  endtask

  task automatic pop();
    consume = 1'b1;
    tick();
    consume = 1'b0;
  endtask

  task automatic clear_unit();
    unit_clr = 1'b1;
    tick();
    unit_clr = 1'b0;
  endtask

  function automatic logic [DW-1:0] sample(input int b, input int s, input int w, input int k);
    return DW'(b * 7 + s * 31 + w * 5 + k * 257 + 16'h1234);
  endfunction

  // Flag outputs derived from an expected full value
  task automatic chk_flags(input string req, input int exp_full);
    chk_eq({req, " full"}, full, exp_full);
    chk_eq("R7 wr_irq", wr_irq, (wr_irq_en && exp_full == 0) ? 1 : 0);
    chk_eq("R8 dma_req", dma_req, (dma_wr_en && exp_full == 0) ? 1 : 0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 0, 1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    int bases [3] = '{0, 100, 250};
    repeat (3) tick();
    rst_n = 1'b1;
    @(negedge clk);

    // R9: reset state
    chk_eq("R9 full after reset", full, 0);
    chk_eq("R9 ovfl after reset", ovfl, 0);
    chk_eq("R2 ready while stopped", s_ready, 0);
    chk_eq("R8 dma_req after reset", dma_req, 0);

    // R2: beat while stopped is ignored
    cfg_base = 8'd10; cfg_size = 8'd4; cfg_wm = 2'd0;
    clear_unit();
    push(16'hDEAD);
    run = 1'b1;
    tick();
    chk_eq("R2 ready while running", s_ready, 1);
    push(16'h0BEE);
    chk_eq("R2 stopped beat not stored", oldest_data, 16'h0BEE);

    // R6: release while stopped is ignored
    push(16'h0C0C);
    run = 1'b0;
    pop();
    run = 1'b1;
    chk_eq("R6 stopped release ignored", oldest_data, 16'h0BEE);
    pop();
    chk_eq("R6 release advances", oldest_data, 16'h0C0C);
    pop();

    // R8: enable captured while stopped, frozen while running
    run = 1'b0; dma_wr_en = 1'b1; tick();
    run = 1'b1; dma_wr_en = 1'b0; tick();
    chk_eq("R8 dma held from stopped capture", dma_req, 1);
    run = 1'b0; tick();
    chk_eq("R8 dma recaptured while stopped", dma_req, 0);
    run = 1'b1;

    // Main sweep: R1 R3 R4 R5 R6 R7 R8 R9
    foreach (bases[bi]) begin
      for (int sz = 1; sz <= 9; sz++) begin
        for (int w = 0; w < 4; w++) begin
          int b;
          int thr;
          b = bases[bi];
          thr = 1 << w;
          run = 1'b0;
          dma_wr_en = sz[0];
          cfg_base = AW'(b); cfg_size = AW'(sz); cfg_wm = 2'(w);
          wr_irq_en = w[0]; ovf_irq_en = w[1];
          tick();
          clear_unit();
          chk_eq("R9 ovfl after clear", ovfl, 0);
          chk_eq("R9 full right after clear", full, 0);
          run = 1'b1;
          repeat (3) tick();
          // fill one word at a time: R4 threshold, R5 lag
          for (int k = 0; k <= sz; k++) begin
            chk_flags("R4", (sz - k < thr) ? 1 : 0);
            if (k < sz) begin
              push(sample(b, sz, w, k));
              tick(); tick();
              chk_eq("R5 full before lag", full, (sz - k < thr) ? 1 : 0);
              tick();
            end
          end
          // R3: beat into a full window
          chk_eq("R3 ovfl before drop", ovfl, 0);
          push(16'hFFFF);
          chk_eq("R3 ovfl after drop", ovfl, 1);
          chk_eq("R7 ovf_irq", ovf_irq, w[1] ? 1 : 0);
          // drain: R1 order, R3 no overwrite, R5 falling lag
          for (int i = 0; i < sz; i++) begin
            chk_eq("R1 drain order", oldest_data, sample(b, sz, w, i));
            pop();
            tick(); tick();
            chk_eq("R5 full before release lag", full, (i < thr) ? 1 : 0);
            tick();
            chk_flags("R5", (i + 1 < thr) ? 1 : 0);
          end
          chk_eq("R3 ovfl sticky", ovfl, 1);
          // R6: release on empty ignored
          pop();
          push(sample(b, sz, w, 100));
          chk_eq("R6 empty release ignored", oldest_data, sample(b, sz, w, 100));
          pop();
          // R1: streaming beyond the window
          for (int i = 0; i < 2 * sz + 3; i++) begin
            push(sample(b, sz, w, 200 + i));
            chk_eq("R1 wrap stream", oldest_data, sample(b, sz, w, 200 + i));
            pop();
          end
          chk_eq("R3 ovfl still sticky", ovfl, 1);
          clear_unit();
          chk_eq("R9 clear drops ovfl", ovfl, 0);
        end
      end
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule